// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Emulator

This block stands in for a 4-bit-wide asynchronous DRAM with a multiplexed address bus. It runs inside a fast clock domain and samples the active-low row strobe, column strobe, write enable and output enable once per clock. From the order in which those strobes fall, it works out whether a cycle is a read, a write, a row-only refresh or a column-before-row refresh. It then acts on a small register-file backing store. The data output is given as a nibble plus a drive-enable flag, in place of a real three-state pad.

The row address is captured when the row strobe is first seen low. The column address is captured when the column strobe is first seen low inside that cycle. If the column strobe is already low when the row strobe falls, the cycle is a refresh that takes its row from an internal counter. In that case the external address is ignored, no data moves, and the counter advances. Each row-strobe fall reports the refreshed row for one clock. Two programmable clock counts bound the shortest allowed row-active time and the shortest allowed row-precharge time. A one-clock error pulse marks any cycle that breaks either bound.

Top module: `dram_strobe_model`

## Requirements
- R1: After reset, dout_en, timing_err and refresh_pulse are low, and the first column-before-row refresh reports row 0.
- R2: In a normal cycle, the row is taken from addr at the sample where ras_n is first seen low with cas_n high. The column is taken from addr at the sample where cas_n is first seen low while ras_n is low. The storage cell is {row[2:0], col[2:0]}, and higher address bits do not select storage.
- R3: A write happens at the later of the column-strobe fall and the write-enable fall, with both low and ras_n low. din is stored as sampled at that clock.
- R4: dout_en is high one clock after any sample where ras_n, cas_n and oe_n are low, we_n is high, and a column is latched in a normal cycle. dout then equals the stored nibble of the addressed cell. In every other case dout_en is low.
- R5: Raising cas_n drops the latched column. A new cas_n fall while ras_n stays low latches a new column in the same row.
- R6: A cycle whose ras_n fall is sampled with cas_n already low is a refresh. It reports the internal counter as the row, ignores addr, and then adds one to the counter, which wraps from 2047 to 0.
- R7: During such a refresh cycle, until ras_n and cas_n are both high, no write happens and dout_en stays low.
- R8: refresh_pulse is high for exactly one clock after each ras_n fall. For a normal cycle, refresh_row holds the addr value sampled at that fall.
- R9: timing_err pulses for one clock after a ras_n rise if ras_n was sampled low on fewer than min_active clocks.
- R10: timing_err pulses for one clock after a ras_n fall if ras_n was sampled high on fewer than min_precharge clocks since its last rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 4 | Write data |
| min_active | input | 8 | Minimum row-active clocks |
| min_precharge | input | 8 | Minimum row-precharge clocks |
| dout | output | 4 | Read data value |
| dout_en | output | 1 | Read data drive enable |
| refresh_pulse | output | 1 | One-clock mark of a refreshed row |
| refresh_row | output | 11 | Row refreshed by the last ras_n fall |
| timing_err | output | 1 | One-clock timing violation pulse |

## Verification
Writes are applied once with the write enable falling before the column strobe and once with it falling after. Reads are applied with the output enable low from the start and with it falling late. Comparing these shows whether each operation starts at the later strobe edge and not at the first one. Page-mode column changes separate the per-column latch from the per-row latch, and upper address bits that differ between writes and reads show that those bits are kept out of storage selection. A run of refresh cycles long enough to wrap the counter, with the output enable held low throughout, tells the refresh decode apart from a read. Deliberately short active and precharge phases, followed by random strobe sequences, exercise every edge ordering against the bench model.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras: 1'b1, cas: 1'b1, we: 1'b1};

endpackage

// File: rtl/strobe_edges.sv
module strobe_edges
  import dram_emu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t cur,
  output strobe_t prev
);

  strobe_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= STROBE_IDLE;
    else        prev_q <= cur;
  end

  assign prev = prev_q;

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] count
);

  logic [ROW_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (inc) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R6: each refresh advances the row by one, wrapping at the width
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc) |-> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             ras_prev,
  input  logic [CNT_W-1:0] min_active,
  input  logic [CNT_W-1:0] min_precharge,
  output logic             timing_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] act_q, act_d, pre_q, pre_d;
  logic             err_q, err_d;
  logic             rise, fall;

  assign rise = ~ras_prev & ras_n;
  assign fall = ras_prev & ~ras_n;

  always_comb begin
    act_d = act_q;
    pre_d = pre_q;
    if (!ras_n) begin
      if (ras_prev)               act_d = {{(CNT_W-1){1'b0}}, 1'b1};
      else if (act_q != CNT_MAX)  act_d = act_q + 1'b1;
    end else begin
      if (!ras_prev)              pre_d = {{(CNT_W-1){1'b0}}, 1'b1};
      else if (pre_q != CNT_MAX)  pre_d = pre_q + 1'b1;
    end
    err_d = (rise && (act_q < min_active)) || (fall && (pre_q < min_precharge));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      pre_q <= CNT_MAX;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      pre_q <= pre_d;
      err_q <= err_d;
    end
  end

  assign timing_err = err_q;

  // R9 / R10: a violation is only flagged on a row-strobe transition
  p_err_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ras_prev != $past(ras_prev)));

endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int DATA_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_emu_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  localparam int IDX_W    = ROW_IDX_W + COL_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           cur,
  input  strobe_t           prev,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] cbr_row,
  output logic              cbr_inc,
  output logic              wr_en,
  output logic              rd_en,
  output logic [IDX_W-1:0]  cell_idx,
  output logic              ref_pulse,
  output logic [ADDR_W-1:0] ref_row
);

  logic                 is_cbr_q, is_cbr_d;
  logic                 colv_q, colv_d;
  logic [ROW_IDX_W-1:0] row_q, row_d;
  logic [COL_IDX_W-1:0] col_q, col_d, col_sel;
  logic                 pulse_q;
  logic [ADDR_W-1:0]    rrow_q, rrow_d;

  logic ras_fall, cas_fall, we_fall, cbr_start, cbr_eff, cas_hit, colv_eff, access_ok;

  always_comb begin
    ras_fall  = prev.ras & ~cur.ras;
    cas_fall  = prev.cas & ~cur.cas;
    we_fall   = prev.we  & ~cur.we;
    cbr_start = ras_fall & ~cur.cas;
    cbr_eff   = is_cbr_q | cbr_start;
    cas_hit   = cas_fall & ~cur.ras & ~cbr_eff;
    colv_eff  = cas_hit | (colv_q & ~cur.cas);
    col_sel   = cas_hit ? addr[COL_IDX_W-1:0] : col_q;
    access_ok = ~cur.ras & ~cur.cas & ~cbr_eff & colv_eff;

    wr_en    = access_ok & ~cur.we & (cas_hit | we_fall);
    rd_en    = access_ok & cur.we & ~oe_n;
    cell_idx = {row_q, col_sel};
    cbr_inc  = cbr_start;

    is_cbr_d = is_cbr_q;
    if (cur.ras && cur.cas) is_cbr_d = 1'b0;
    else if (ras_fall)      is_cbr_d = cbr_start;

    colv_d = colv_q;
    if (cur.cas)      colv_d = 1'b0;
    else if (cas_hit) colv_d = 1'b1;

    row_d = row_q;
    if (ras_fall && !cbr_start) row_d = addr[ROW_IDX_W-1:0];

    col_d = col_sel;

    rrow_d = rrow_q;
    if (ras_fall) rrow_d = cbr_start ? cbr_row : addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_cbr_q <= 1'b0;
      colv_q   <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      pulse_q  <= 1'b0;
      rrow_q   <= '0;
    end else begin
      is_cbr_q <= is_cbr_d;
      colv_q   <= colv_d;
      row_q    <= row_d;
      col_q    <= col_d;
      pulse_q  <= ras_fall;
      rrow_q   <= rrow_d;
    end
  end

  assign ref_pulse = pulse_q;
  assign ref_row   = rrow_q;

endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model
  import dram_emu_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 4,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  min_active,
  input  logic [CNT_W-1:0]  min_precharge,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              refresh_pulse,
  output logic [ADDR_W-1:0] refresh_row,
  output logic              timing_err
);

  localparam int IDX_W = ROW_IDX_W + COL_IDX_W;

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  strobe_t           cur, prev;
  logic              cbr_inc, wr_en, rd_en;
  logic [IDX_W-1:0]  cell_idx;
  logic [ADDR_W-1:0] cbr_row;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              den_q;

  assign cur = '{ras: ras_n, cas: cas_n, we: we_n};

  strobe_edges u_edges (
    .clk (clk), .rst_n (rst_n_i), .cur (cur), .prev (prev)
  );

  refresh_row_counter #(.ROW_W(ADDR_W)) u_rcnt (
    .clk (clk), .rst_n (rst_n_i), .inc (cbr_inc), .count (cbr_row)
  );

  dram_cycle_ctrl #(
    .ADDR_W (ADDR_W), .ROW_IDX_W (ROW_IDX_W), .COL_IDX_W (COL_IDX_W)
  ) u_ctrl (
    .clk (clk), .rst_n (rst_n_i), .cur (cur), .prev (prev), .oe_n (oe_n),
    .addr (addr), .cbr_row (cbr_row), .cbr_inc (cbr_inc), .wr_en (wr_en),
    .rd_en (rd_en), .cell_idx (cell_idx), .ref_pulse (refresh_pulse),
    .ref_row (refresh_row)
  );

  cell_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cells (
    .clk (clk), .wr_en (wr_en), .idx (cell_idx), .wdata (din), .rdata (rdata)
  );

  strobe_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk), .rst_n (rst_n_i), .ras_n (ras_n), .ras_prev (prev.ras),
    .min_active (min_active), .min_precharge (min_precharge),
    .timing_err (timing_err)
  );

  always_comb begin
    dout_d = dout_q;
    if (rd_en) dout_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dout_q <= '0;
      den_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      den_q  <= rd_en;
    end
  end

  assign dout    = dout_q;
  assign dout_en = den_q;

  // R4: the output is only driven after a sample with all read strobes active
  p_den_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    dout_en |-> $past(!ras_n && !cas_n && !oe_n && we_n));

  // R7: a refresh started with the column strobe low never drives data
  p_hiz_cbr_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($fell(ras_n) && !cas_n) |=> !dout_en);

endmodule

// File: tb/dram_strobe_model_test.sv
module dram_strobe_model_test;

  localparam int MA = 4;
  localparam int MP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, cas_n, we_n, oe_n;
  logic [10:0] addr;
  logic [3:0]  din;
  logic [7:0]  min_active, min_precharge;
  logic [3:0]  dout;
  logic        dout_en, refresh_pulse, timing_err;
  logic [10:0] refresh_row;

  always #2 clk = ~clk;

  dram_strobe_model uut (
    .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .oe_n (oe_n), .addr (addr), .din (din), .min_active (min_active),
    .min_precharge (min_precharge), .dout (dout), .dout_en (dout_en),
    .refresh_pulse (refresh_pulse), .refresh_row (refresh_row),
    .timing_err (timing_err)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // requirement-level model state
  logic [3:0]  m_mem [64];
  logic        m_ras = 1'b1, m_cas = 1'b1, m_we = 1'b1;
  logic        m_cbr = 1'b0, m_colv = 1'b0;
  logic [2:0]  m_row = '0, m_col = '0;
  int unsigned m_cnt = 0;
  int unsigned lo_cnt = 0, hi_cnt = 255;

  function automatic int unsigned sat(input int unsigned v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // apply current drive for one clock and check all outputs against the model
  task automatic step(input string dtag = "R4");
    logic fr, cf, wf, exp_err, exp_pulse, exp_den, acc;
    int   exp_row;
    logic [3:0] exp_dout;
    string etag;
    fr = m_ras & ~ras_n;
    cf = m_cas & ~cas_n;
    wf = m_we  & ~we_n;
    exp_err = (!m_ras && ras_n && lo_cnt < MA) || (m_ras && !ras_n && hi_cnt < MP);
    etag = (!m_ras && ras_n) ? "R9" : "R10";
    exp_pulse = fr;
    exp_row = -1;
    if (fr) begin
      m_cbr = ~cas_n;
      if (m_cbr) begin
        exp_row = int'(m_cnt);
        m_cnt = (m_cnt + 1) % 2048;
      end else begin
        exp_row = int'(addr);
        m_row = addr[2:0];
      end
    end
    if (cas_n) m_colv = 1'b0;
    else if (cf && !ras_n && !m_cbr) begin
      m_col = addr[2:0];
      m_colv = 1'b1;
    end
    acc = !ras_n && !cas_n && !m_cbr && m_colv;
    if (acc && !we_n && (cf || wf)) m_mem[{m_row, m_col}] = din;
    exp_den  = acc && we_n && !oe_n;
    exp_dout = m_mem[{m_row, m_col}];
    if (ras_n && cas_n) m_cbr = 1'b0;
    if (!ras_n) lo_cnt = m_ras ? 1 : sat(lo_cnt);
    else        hi_cnt = !m_ras ? 1 : sat(hi_cnt);
    m_ras = ras_n; m_cas = cas_n; m_we = we_n;
    @(posedge clk);
    @(negedge clk);
    check(etag, "timing_err", int'(timing_err), int'(exp_err));
    check("R8", "refresh_pulse", int'(refresh_pulse), int'(exp_pulse));
    if (exp_row >= 0)
      check((m_cbr && fr) ? "R6" : "R8", "refresh_row", int'(refresh_row), exp_row);
    check(m_cbr ? "R7" : "R4", "dout_en", int'(dout_en), int'(exp_den));
    if (exp_den) check(dtag, "dout", int'(dout), int'(exp_dout));
  endtask

  task automatic idle_drive();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // R2 / R3: write cycle, write enable early or late relative to the column strobe
  task automatic wcycle(input logic [10:0] r, input logic [10:0] c, input logic [3:0] d, input bit late);
    addr = r; ras_n = 1'b0; step("R3");
    addr = c; din = d; cas_n = 1'b0;
    if (!late) we_n = 1'b0;
    step("R3");
    if (late) we_n = 1'b0;
    step("R3");
    addr = $urandom; din = $urandom; step("R3");
    idle_drive(); step("R3"); step("R3"); step("R3");
  endtask

  // R4: read cycle, output enable early or late
  task automatic rcycle(input logic [10:0] r, input logic [10:0] c, input bit late, input string tag);
    addr = r; ras_n = 1'b0; if (!late) oe_n = 1'b0; step(tag);
    addr = c; cas_n = 1'b0; step(tag);
    oe_n = 1'b0; step(tag);
    addr = $urandom; step(tag);
    idle_drive(); step(tag); step(tag); step(tag);
  endtask

  // R6 / R7: refresh with the column strobe leading, read strobes held active
  task automatic cbr_cycle();
    cas_n = 1'b0; oe_n = 1'b0; addr = $urandom; step("R7");
    ras_n = 1'b0; step("R7");
    step("R7"); step("R7"); step("R7");
    idle_drive(); step("R7"); step("R7"); step("R7");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; idle_drive(); addr = '0; din = '0;
    min_active = 8'(MA); min_precharge = 8'(MP);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "dout_en", int'(dout_en), 0);
    check("R1", "timing_err", int'(timing_err), 0);
    check("R1", "refresh_pulse", int'(refresh_pulse), 0);
    rst_n = 1'b1;
    repeat (3) step("R1");

    // R1 / R6: first refresh after reset reports row 0
    cbr_cycle();

    // R2 / R3: fill every cell, upper address bits random
    for (int i = 0; i < 64; i++) begin
      logic [10:0] r, c;
      r = {8'($urandom), 3'(i >> 3)};
      c = {8'($urandom), 3'(i)};
      wcycle(r, c, 4'($urandom), (i % 2) == 1);
    end

    // R2 / R4: read back with other upper bits, OE early and late
    for (int i = 0; i < 64; i++) begin
      logic [10:0] r, c;
      r = {8'($urandom), 3'(i >> 3)};
      c = {8'($urandom), 3'(i)};
      rcycle(r, c, (i % 3) == 0, "R2");
    end

    // R5: page mode, several columns under one row
    for (int p = 0; p < 8; p++) begin
      addr = 11'(p); ras_n = 1'b0; oe_n = 1'b0; step("R5");
      for (int c = 0; c < 4; c++) begin
        addr = 11'($urandom); cas_n = 1'b0; step("R5");
        step("R5");
        cas_n = 1'b1; step("R5");
      end
      idle_drive(); step("R5"); step("R5"); step("R5");
    end

    // R3: late write then page read of the same cell
    wcycle(11'h005, 11'h003, 4'hA, 1'b1);
    rcycle(11'h005, 11'h003, 1'b1, "R3");

    // R6: enough refreshes to wrap the counter
    for (int k = 0; k < 2050; k++) cbr_cycle();
    // R8: row-only refresh
    addr = 11'h7A5; ras_n = 1'b0; step("R8"); step("R8"); step("R8"); step("R8");
    idle_drive(); step("R8"); step("R8"); step("R8");

    // R9: short active phase; R10: short precharge phase
    addr = 11'h011; ras_n = 1'b0; step("R9"); step("R9");
    ras_n = 1'b1; step("R9");
    ras_n = 1'b0; step("R10"); step("R10"); step("R10"); step("R10");
    ras_n = 1'b1; step("R10"); step("R10"); step("R10");

    // random strobe sequences checked against the model
    for (int k = 0; k < 5000; k++) begin
      if (($urandom % 4) == 0) ras_n = ~ras_n;
      if (($urandom % 3) == 0) cas_n = ~cas_n;
      if (($urandom % 4) == 0) we_n  = ~we_n;
      if (($urandom % 3) == 0) oe_n  = ~oe_n;
      addr = 11'($urandom); din = 4'($urandom);
      step("R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule